// File: doc/BRIEF.md
# IO Address Translation Unit

This block sits between DMA-capable devices and main memory and turns each device address into a physical address. The lookup goes through a small, fully associative translation cache. Entries of four different page sizes share the cache, and each entry is tagged with a context number, so several translation contexts use the same storage. Software loads or clears entries through a register-style write port. It can drop every entry of a context in one cycle, and it can set a per-context option that splits the address space into a low half and a high half, each with its own entries. A fixed address window that carries interrupt messages is never translated. Requests in that window come back marked as bypass.

A request carries a context number, a requester ID, an address and a read/write flag. It is accepted on a valid/ready handshake, looked up in one cycle, and answered on a valid/ready response port. If a request misses or breaks a permission, it becomes a held fault. The block raises a fault interrupt and shows the requester ID, the address and a reason code. No new request is taken until software answers. The answer is either retry, which runs the lookup again with the current cache contents, or terminate, which closes the transaction with an error response. Software brackets map changes with update-start and update-done strobes, and no lookup is issued while an update is open.

Top module: `io_xlate_unit`

## Requirements
- R1: An accepted request that hits gets a response on the next clock edge. The physical address keeps the request's offset bits below the entry's page size and takes the entry's physical base in all bits above that size.
- R2: The page size code is 0 for 4 KiB, 1 for 64 KiB, 2 for 1 MiB and 3 for 16 MiB. It sets how many low address bits count as offset: 12, 16, 20 or 24.
- R3: A programming write with cfg_valid=1 whose virtual or physical base has any offset bit set for its size is rejected. The entry keeps its old contents, and cfg_err is 1 for the one cycle after the write. Writes with cfg_valid=0 unmap the entry and are never rejected.
- R4: An entry matches only requests whose context number equals the entry's context number.
- R5: A request whose address lies in 0xFEE00000..0xFEEFFFFF is answered with rsp_bypass=1 and rsp_paddr equal to the request address. This holds even when an entry covers that address. Addresses just outside the window are translated normally.
- R6: When the split bit of a context is 1, a request uses only that context's entries whose high tag equals request address bit 31. When the split bit is 0, the request uses only entries whose high tag is 0.
- R7: Permission bits are bit 0 read, bit 1 write and bit 2 execute. A write that hits an entry without write permission faults with code 5. A read that hits an entry without read permission faults with code 4. A successful response reports the entry's execute bit on rsp_exec.
- R8: A request that matches no entry and is outside the bypass window faults with code 1.
- R9: While a fault is held, flt_irq is 1 and flt_rid, flt_addr and flt_code show the faulting request. During that time req_ready is 0.
- R10: The answer flt_ans_retry=1 runs the lookup again on the held request with the current entries. The answer flt_ans_retry=0 produces a response with rsp_err=1 and rsp_paddr=0.
- R11: After an upd_start strobe, req_ready stays 0 until an upd_done strobe.
- R12: If several entries match, the one with the smallest page size is used.
- R13: An invalidate strobe clears every entry of the named context in one cycle and leaves the entries of other contexts untouched.
- R14: While rsp_valid is 1 and rsp_ready is 0, the response holds its value and no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | 3 | Entry slot to write |
| cfg_valid | input | 1 | 1 maps the slot, 0 unmaps it |
| cfg_ctx | input | 3 | Context number of the entry |
| cfg_size | input | 2 | Page size code |
| cfg_hi | input | 1 | High-half tag of the entry |
| cfg_vbase | input | 32 | Virtual base |
| cfg_pbase | input | 32 | Physical base |
| cfg_perm | input | 3 | Permissions: execute, write, read |
| cfg_err | output | 1 | Misaligned write rejected (one cycle) |
| inv_en | input | 1 | Invalidate-context strobe |
| inv_ctx | input | 3 | Context to invalidate |
| split_we | input | 1 | Split-bit write strobe |
| split_ctx | input | 3 | Context whose split bit is written |
| split_on | input | 1 | New split bit value |
| upd_start | input | 1 | Map update begins |
| upd_done | input | 1 | Map update ends |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when valid and ready |
| req_ctx | input | 3 | Request context number |
| req_rid | input | 8 | Requester ID |
| req_addr | input | 32 | Device address |
| req_wr | input | 1 | 1 write, 0 read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when valid and ready |
| rsp_paddr | output | 32 | Physical address |
| rsp_bypass | output | 1 | Address passed through untranslated |
| rsp_err | output | 1 | Transaction terminated |
| rsp_exec | output | 1 | Execute permission of the hit page |
| flt_irq | output | 1 | Fault held |
| flt_rid | output | 8 | Requester ID of the held fault |
| flt_addr | output | 32 | Address of the held fault |
| flt_code | output | 3 | Fault reason code |
| flt_ans_valid | input | 1 | Software answer strobe |
| flt_ans_retry | input | 1 | 1 retry, 0 terminate |

## Verification
The assertions assume that reset is held for at least one edge and that slot indices stay below the entry count. They also assume that a fault answer is given only while flt_irq is high and that every upd_start is followed by an upd_done. The bench keeps to these limits. It gives answers only after it sees the interrupt, always pairs the update strobes, draws slot indices from the valid range, and builds random entries with aligned bases. Random addresses are either placed inside a shadow entry or drawn freely, so hits, misses, bypass and permission faults all occur.

// File: rtl/io_xlate_pkg.sv
// Shared encodings for the IO address translation unit.
// Assumes page sizes are the four fixed powers of two listed below.
package io_xlate_pkg;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_REPLAY,
        ST_KILL
    } hold_st_e;

    localparam logic [2:0] FC_NONE        = 3'd0;
    localparam logic [2:0] FC_NOT_PRESENT = 3'd1;
    localparam logic [2:0] FC_READ_DENY   = 3'd4;
    localparam logic [2:0] FC_WRITE_DENY  = 3'd5;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;

    // Number of offset bits kept from the request for a given size code.
    function automatic int unsigned pg_off_bits(input logic [1:0] sz);
        case (sz)
            2'd0:    return 12;
            2'd1:    return 16;
            2'd2:    return 20;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/io_xlate_entry_store.sv
// Entry storage of the translation cache.
// Holds NUM_ENT entries, applies software writes with an alignment check,
// and clears all entries of one context on an invalidate strobe.
// Assumes cfg_idx < NUM_ENT. On a same-cycle invalidate and write, the write
// to its slot takes effect.
module io_xlate_entry_store
    import io_xlate_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_ENT = 8,
    parameter int CTX_W   = 3,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_valid,
    input  logic [CTX_W-1:0]  cfg_ctx,
    input  logic [1:0]        cfg_size,
    input  logic              cfg_hi,
    input  logic [ADDR_W-1:0] cfg_vbase,
    input  logic [ADDR_W-1:0] cfg_pbase,
    input  logic [2:0]        cfg_perm,
    input  logic              inv_en,
    input  logic [CTX_W-1:0]  inv_ctx,
    output logic [NUM_ENT-1:0] ent_valid,
    output logic [CTX_W-1:0]  ent_ctx   [NUM_ENT],
    output logic [1:0]        ent_size  [NUM_ENT],
    output logic [NUM_ENT-1:0] ent_hi,
    output logic [ADDR_W-1:0] ent_vbase [NUM_ENT],
    output logic [ADDR_W-1:0] ent_pbase [NUM_ENT],
    output logic [2:0]        ent_perm  [NUM_ENT],
    output logic              cfg_err
);

    logic [ADDR_W-1:0] cfg_off_mask;
    logic              cfg_misal;

    // Offset mask for the size being written, and the alignment verdict.
    always_comb begin
        cfg_off_mask = ~({ADDR_W{1'b1}} << pg_off_bits(cfg_size));
        cfg_misal    = |((cfg_vbase | cfg_pbase) & cfg_off_mask);
    end

    // Entry registers: invalidate by context, then accepted writes on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_hi    <= '0;
            for (int i = 0; i < NUM_ENT; i++) begin
                ent_ctx[i]   <= '0;
                ent_size[i]  <= '0;
                ent_vbase[i] <= '0;
                ent_pbase[i] <= '0;
                ent_perm[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_ENT; i++) begin
                if (inv_en && ent_ctx[i] == inv_ctx) begin
                    ent_valid[i] <= 1'b0;
                end
                if (cfg_we && cfg_idx == IDX_W'(i) && (!cfg_valid || !cfg_misal)) begin
                    ent_valid[i] <= cfg_valid;
                    ent_ctx[i]   <= cfg_ctx;
                    ent_size[i]  <= cfg_size;
                    ent_hi[i]    <= cfg_hi;
                    ent_vbase[i] <= cfg_vbase;
                    ent_pbase[i] <= cfg_pbase;
                    ent_perm[i]  <= cfg_perm;
                end
            end
        end
    end

    // One-cycle error flag for a rejected write.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= cfg_we && cfg_valid && cfg_misal;
    end

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent_chk
        AST_MISALIGN_KEEPS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_valid && cfg_misal && cfg_idx == IDX_W'(g) && !inv_en)
            |=> ($stable(ent_valid[g]) && $stable(ent_vbase[g]) && $stable(ent_pbase[g]))); // R3
        AST_INV_CLEARS_CTX: assert property (@(posedge clk) disable iff (!rst_n)
            (inv_en && ent_ctx[g] == inv_ctx && !(cfg_we && cfg_idx == IDX_W'(g)))
            |=> !ent_valid[g]); // R13
    end

endmodule

// File: rtl/io_xlate_ctx_cfg.sv
// Per-context split option.
// Holds one split bit per context and returns the bit of the looked-up context.
module io_xlate_ctx_cfg #(
    parameter int CTX_W   = 3,
    localparam int NUM_CTX = 1 << CTX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             split_we,
    input  logic [CTX_W-1:0] split_ctx,
    input  logic             split_on,
    input  logic [CTX_W-1:0] q_ctx,
    output logic             q_split
);

    logic [NUM_CTX-1:0] split_q;

    // Split bit register file, written one context at a time.
    always_ff @(posedge clk) begin
        if (!rst_n)        split_q            <= '0;
        else if (split_we) split_q[split_ctx] <= split_on;
    end

    // Read port for the lookup context.
    always_comb q_split = split_q[q_ctx];

endmodule

// File: rtl/io_xlate_lookup.sv
// Combinational lookup through the fully associative cache.
// Matches context, half tag and page number per entry, picks the smallest
// matching page, checks permissions, and overrides everything for the
// interrupt bypass window. Assumes entry bases are aligned to their size.
module io_xlate_lookup
    import io_xlate_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_ENT = 8,
    parameter int CTX_W   = 3,
    parameter logic [ADDR_W-1:0] BYP_BASE = 'hFEE00000,
    parameter int BYP_LOG2 = 20,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic [NUM_ENT-1:0] ent_valid,
    input  logic [CTX_W-1:0]   ent_ctx   [NUM_ENT],
    input  logic [1:0]         ent_size  [NUM_ENT],
    input  logic [NUM_ENT-1:0] ent_hi,
    input  logic [ADDR_W-1:0]  ent_vbase [NUM_ENT],
    input  logic [ADDR_W-1:0]  ent_pbase [NUM_ENT],
    input  logic [2:0]         ent_perm  [NUM_ENT],
    input  logic [CTX_W-1:0]   q_ctx,
    input  logic [ADDR_W-1:0]  q_addr,
    input  logic               q_wr,
    input  logic               q_split,
    output logic               l_bypass,
    output logic               l_fault,
    output logic [2:0]         l_code,
    output logic [ADDR_W-1:0]  l_paddr,
    output logic               l_exec
);

    logic               q_tag;
    logic [NUM_ENT-1:0] hit;
    logic               found;
    logic [IDX_W-1:0]   best;
    logic [1:0]         best_sz;
    logic [ADDR_W-1:0]  best_mask;
    logic [2:0]         best_perm;

    // Half tag the request must carry.
    always_comb q_tag = q_split ? q_addr[ADDR_W-1] : 1'b0;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_match
        logic [ADDR_W-1:0] pg_mask;
        // Page-number mask of this entry and its match verdict.
        always_comb begin
            pg_mask = {ADDR_W{1'b1}} << pg_off_bits(ent_size[g]);
            hit[g]  = ent_valid[g] && (ent_ctx[g] == q_ctx) && (ent_hi[g] == q_tag)
                      && (((q_addr ^ ent_vbase[g]) & pg_mask) == '0);
        end
    end

    // Smallest page wins; lowest slot breaks ties among equal sizes.
    always_comb begin
        found   = 1'b0;
        best    = '0;
        best_sz = 2'd3;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (hit[i] && (!found || ent_size[i] < best_sz)) begin
                found   = 1'b1;
                best    = IDX_W'(i);
                best_sz = ent_size[i];
            end
        end
        best_mask = ~({ADDR_W{1'b1}} << pg_off_bits(best_sz));
        best_perm = ent_perm[best];
    end

    // Verdict: bypass window first, then miss, then permissions.
    always_comb begin
        l_bypass = (q_addr >> BYP_LOG2) == (BYP_BASE >> BYP_LOG2);
        l_fault  = 1'b0;
        l_code   = FC_NONE;
        l_exec   = 1'b0;
        l_paddr  = (ent_pbase[best] & ~best_mask) | (q_addr & best_mask);
        if (l_bypass) begin
            l_paddr = q_addr;
        end else if (!found) begin
            l_fault = 1'b1;
            l_code  = FC_NOT_PRESENT;
        end else if (q_wr && !best_perm[PERM_W]) begin
            l_fault = 1'b1;
            l_code  = FC_WRITE_DENY;
        end else if (!q_wr && !best_perm[PERM_R]) begin
            l_fault = 1'b1;
            l_code  = FC_READ_DENY;
        end else begin
            l_exec  = best_perm[PERM_X];
        end
    end

endmodule

// File: rtl/io_xlate_unit.sv
// Top of the IO address translation unit.
// Accepts one request per cycle when free, looks it up in one cycle,
// registers the response, and parks a faulting request until software
// answers retry or terminate. Lookups wait while a map update is open.
// Assumes flt_ans_valid is only pulsed while flt_irq is high.
module io_xlate_unit
    import io_xlate_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_ENT = 8,
    parameter int CTX_W   = 3,
    parameter int RID_W   = 8,
    parameter logic [ADDR_W-1:0] BYP_BASE = 'hFEE00000,
    parameter int BYP_LOG2 = 20,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_valid,
    input  logic [CTX_W-1:0]  cfg_ctx,
    input  logic [1:0]        cfg_size,
    input  logic              cfg_hi,
    input  logic [ADDR_W-1:0] cfg_vbase,
    input  logic [ADDR_W-1:0] cfg_pbase,
    input  logic [2:0]        cfg_perm,
    output logic              cfg_err,
    input  logic              inv_en,
    input  logic [CTX_W-1:0]  inv_ctx,
    input  logic              split_we,
    input  logic [CTX_W-1:0]  split_ctx,
    input  logic              split_on,
    input  logic              upd_start,
    input  logic              upd_done,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [RID_W-1:0]  req_rid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_bypass,
    output logic              rsp_err,
    output logic              rsp_exec,
    output logic              flt_irq,
    output logic [RID_W-1:0]  flt_rid,
    output logic [ADDR_W-1:0] flt_addr,
    output logic [2:0]        flt_code,
    input  logic              flt_ans_valid,
    input  logic              flt_ans_retry
);

    logic [NUM_ENT-1:0] ent_valid;
    logic [CTX_W-1:0]   ent_ctx   [NUM_ENT];
    logic [1:0]         ent_size  [NUM_ENT];
    logic [NUM_ENT-1:0] ent_hi;
    logic [ADDR_W-1:0]  ent_vbase [NUM_ENT];
    logic [ADDR_W-1:0]  ent_pbase [NUM_ENT];
    logic [2:0]         ent_perm  [NUM_ENT];

    hold_st_e           st;
    logic               upd_busy;
    logic               slot_free, ext_go, rep_go, kill_go, look_go;
    logic [CTX_W-1:0]   h_ctx, q_ctx;
    logic [ADDR_W-1:0]  h_addr, q_addr;
    logic               h_wr, q_wr;
    logic [RID_W-1:0]   h_rid;
    logic               q_split;
    logic               l_bypass, l_fault, l_exec;
    logic [2:0]         l_code;
    logic [ADDR_W-1:0]  l_paddr;

    io_xlate_entry_store #(.ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT), .CTX_W(CTX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_ctx(cfg_ctx),
        .cfg_size(cfg_size), .cfg_hi(cfg_hi), .cfg_vbase(cfg_vbase), .cfg_pbase(cfg_pbase),
        .cfg_perm(cfg_perm), .inv_en(inv_en), .inv_ctx(inv_ctx),
        .ent_valid(ent_valid), .ent_ctx(ent_ctx), .ent_size(ent_size), .ent_hi(ent_hi),
        .ent_vbase(ent_vbase), .ent_pbase(ent_pbase), .ent_perm(ent_perm),
        .cfg_err(cfg_err)
    );

    io_xlate_ctx_cfg #(.CTX_W(CTX_W)) u_ctx (
        .clk(clk), .rst_n(rst_n),
        .split_we(split_we), .split_ctx(split_ctx), .split_on(split_on),
        .q_ctx(q_ctx), .q_split(q_split)
    );

    io_xlate_lookup #(
        .ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT), .CTX_W(CTX_W),
        .BYP_BASE(BYP_BASE), .BYP_LOG2(BYP_LOG2)
    ) u_look (
        .ent_valid(ent_valid), .ent_ctx(ent_ctx), .ent_size(ent_size), .ent_hi(ent_hi),
        .ent_vbase(ent_vbase), .ent_pbase(ent_pbase), .ent_perm(ent_perm),
        .q_ctx(q_ctx), .q_addr(q_addr), .q_wr(q_wr), .q_split(q_split),
        .l_bypass(l_bypass), .l_fault(l_fault), .l_code(l_code),
        .l_paddr(l_paddr), .l_exec(l_exec)
    );

    // Map update bracket: start opens the stall, done closes it.
    always_ff @(posedge clk) begin
        if (!rst_n)         upd_busy <= 1'b0;
        else if (upd_start) upd_busy <= 1'b1;
        else if (upd_done)  upd_busy <= 1'b0;
    end

    // Issue conditions for external, replayed and terminated transactions.
    always_comb begin
        slot_free = !rsp_valid || rsp_ready;
        req_ready = (st == ST_IDLE) && !upd_busy && slot_free;
        ext_go    = req_valid && req_ready;
        rep_go    = (st == ST_REPLAY) && !upd_busy && slot_free;
        kill_go   = (st == ST_KILL) && slot_free;
        look_go   = ext_go || rep_go;
        q_ctx     = (st == ST_IDLE) ? req_ctx  : h_ctx;
        q_addr    = (st == ST_IDLE) ? req_addr : h_addr;
        q_wr      = (st == ST_IDLE) ? req_wr   : h_wr;
    end

    // Held-request capture on every accepted external request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_ctx  <= '0;
            h_addr <= '0;
            h_wr   <= 1'b0;
            h_rid  <= '0;
        end else if (ext_go) begin
            h_ctx  <= req_ctx;
            h_addr <= req_addr;
            h_wr   <= req_wr;
            h_rid  <= req_rid;
        end
    end

    // Fault hold state machine and reason code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            flt_code <= FC_NONE;
        end else begin
            case (st)
                ST_IDLE: if (ext_go && l_fault) begin
                    st       <= ST_HOLD;
                    flt_code <= l_code;
                end
                ST_HOLD: if (flt_ans_valid) begin
                    st <= flt_ans_retry ? ST_REPLAY : ST_KILL;
                end
                ST_REPLAY: if (rep_go) begin
                    if (l_fault) begin
                        st       <= ST_HOLD;
                        flt_code <= l_code;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                default: if (kill_go) st <= ST_IDLE;
            endcase
        end
    end

    // Response register with valid/ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_paddr  <= '0;
            rsp_bypass <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_exec   <= 1'b0;
        end else if (look_go && !l_fault) begin
            rsp_valid  <= 1'b1;
            rsp_paddr  <= l_paddr;
            rsp_bypass <= l_bypass;
            rsp_err    <= 1'b0;
            rsp_exec   <= l_exec;
        end else if (kill_go) begin
            rsp_valid  <= 1'b1;
            rsp_paddr  <= '0;
            rsp_bypass <= 1'b0;
            rsp_err    <= 1'b1;
            rsp_exec   <= 1'b0;
        end else if (rsp_ready) begin
            rsp_valid  <= 1'b0;
        end
    end

    // Fault report outputs.
    always_comb begin
        flt_irq  = (st == ST_HOLD);
        flt_rid  = h_rid;
        flt_addr = h_addr;
    end

    AST_ACCEPT_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid || flt_irq)); // R1
    AST_BYPASS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_bypass) |-> ((rsp_paddr >> BYP_LOG2) == (BYP_BASE >> BYP_LOG2))); // R5
    AST_FAULT_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
        flt_irq |-> !req_ready); // R9
    AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_irq && !flt_ans_valid) |=> (flt_irq && $stable(flt_addr) && $stable(flt_rid) && $stable(flt_code))); // R9
    AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_start |=> !req_ready); // R11
    AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_err) && !$past(req_ready))); // R14

endmodule

// File: tb/io_xlate_unit_bench.sv
module io_xlate_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0, cfg_valid = 0, cfg_hi = 0;
    logic [2:0]  cfg_idx = 0, cfg_ctx = 0, cfg_perm = 0;
    logic [1:0]  cfg_size = 0;
    logic [31:0] cfg_vbase = 0, cfg_pbase = 0;
    logic        cfg_err;
    logic        inv_en = 0;
    logic [2:0]  inv_ctx = 0;
    logic        split_we = 0, split_on = 0;
    logic [2:0]  split_ctx = 0;
    logic        upd_start = 0, upd_done = 0;
    logic        req_valid = 0, req_wr = 0;
    logic        req_ready;
    logic [2:0]  req_ctx = 0;
    logic [7:0]  req_rid = 0;
    logic [31:0] req_addr = 0;
    logic        rsp_valid, rsp_bypass, rsp_err, rsp_exec;
    logic        rsp_ready = 1;
    logic [31:0] rsp_paddr;
    logic        flt_irq;
    logic [7:0]  flt_rid;
    logic [31:0] flt_addr;
    logic [2:0]  flt_code;
    logic        flt_ans_valid = 0, flt_ans_retry = 0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // Shadow of programmed entries and split bits.
    bit        m_valid [8];
    bit [2:0]  m_ctx   [8];
    bit [1:0]  m_size  [8];
    bit        m_hi    [8];
    bit [31:0] m_vb    [8];
    bit [31:0] m_pb    [8];
    bit [2:0]  m_perm  [8];
    bit        m_split [8];

    always #2 clk = ~clk;

    io_xlate_unit u_io_xlate_unit (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_ctx(cfg_ctx),
        .cfg_size(cfg_size), .cfg_hi(cfg_hi), .cfg_vbase(cfg_vbase), .cfg_pbase(cfg_pbase),
        .cfg_perm(cfg_perm), .cfg_err(cfg_err), .inv_en(inv_en), .inv_ctx(inv_ctx),
        .split_we(split_we), .split_ctx(split_ctx), .split_on(split_on),
        .upd_start(upd_start), .upd_done(upd_done),
        .req_valid(req_valid), .req_ready(req_ready), .req_ctx(req_ctx), .req_rid(req_rid),
        .req_addr(req_addr), .req_wr(req_wr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_bypass(rsp_bypass), .rsp_err(rsp_err), .rsp_exec(rsp_exec),
        .flt_irq(flt_irq), .flt_rid(flt_rid), .flt_addr(flt_addr), .flt_code(flt_code),
        .flt_ans_valid(flt_ans_valid), .flt_ans_retry(flt_ans_retry)
    );

    function automatic bit [31:0] omask(input bit [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_0FFF;
            2'd1:    return 32'h0000_FFFF;
            2'd2:    return 32'h000F_FFFF;
            default: return 32'h00FF_FFFF;
        endcase
    endfunction

    // Expected outcome: kind 0 translate, 1 bypass, 2 fault.
    function automatic void model(input bit [2:0] ctx, input bit [31:0] a, input bit wr,
                                  output int kind, output bit [31:0] pa,
                                  output bit [2:0] code, output bit xb);
        int best = -1;
        bit tag = m_split[ctx] ? a[31] : 1'b0;
        kind = 2; pa = 0; code = 3'd1; xb = 0;
        if (a[31:20] == 12'hFEE) begin
            kind = 1; pa = a; code = 0;
            return;
        end
        for (int i = 0; i < 8; i++) begin
            if (m_valid[i] && m_ctx[i] == ctx && m_hi[i] == tag &&
                ((a ^ m_vb[i]) & ~omask(m_size[i])) == 0) begin
                if (best < 0 || m_size[i] < m_size[best]) best = i;
            end
        end
        if (best < 0) return;
        if (wr && !m_perm[best][1]) code = 3'd5;
        else if (!wr && !m_perm[best][0]) code = 3'd4;
        else begin
            kind = 0; code = 0; xb = m_perm[best][2];
            pa = (m_pb[best] & ~omask(m_size[best])) | (a & omask(m_size[best]));
        end
    endfunction

    task automatic chk(input string r, input bit [31:0] act, input bit [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic prog(input bit [2:0] idx, input bit v, input bit [2:0] ctx, input bit [1:0] sz,
                        input bit hi, input bit [31:0] vb, input bit [31:0] pb, input bit [2:0] perm);
        bit bad = v && (((vb | pb) & omask(sz)) != 0);
        @(negedge clk);
        cfg_we = 1; cfg_idx = idx; cfg_valid = v; cfg_ctx = ctx; cfg_size = sz;
        cfg_hi = hi; cfg_vbase = vb; cfg_pbase = pb; cfg_perm = perm;
        @(negedge clk);
        cfg_we = 0;
        chk("R3 cfg_err", {31'b0, cfg_err}, {31'b0, bad});
        if (!bad) begin
            m_valid[idx] = v; m_ctx[idx] = ctx; m_size[idx] = sz; m_hi[idx] = hi;
            m_vb[idx] = vb; m_pb[idx] = pb; m_perm[idx] = perm;
        end
    endtask

    task automatic set_split(input bit [2:0] ctx, input bit on);
        @(negedge clk);
        split_we = 1; split_ctx = ctx; split_on = on;
        @(negedge clk);
        split_we = 0;
        m_split[ctx] = on;
    endtask

    // Issue one request; report kind 0 ok, 1 bypass, 2 fault, 3 nothing.
    task automatic send(input bit [2:0] ctx, input bit [7:0] rid, input bit [31:0] a, input bit wr,
                        output int kind, output bit [31:0] pa, output bit [2:0] code);
        @(negedge clk);
        req_valid = 1; req_ctx = ctx; req_rid = rid; req_addr = a; req_wr = wr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        pa = rsp_paddr; code = flt_code;
        if (rsp_valid) kind = rsp_bypass ? 1 : 0;
        else if (flt_irq) kind = 2;
        else kind = 3;
    endtask

    task automatic answer(input bit retry);
        @(negedge clk);
        flt_ans_valid = 1; flt_ans_retry = retry;
        @(negedge clk);
        flt_ans_valid = 0;
        @(negedge clk);
    endtask

    // Request plus full comparison against the model; faults are terminated.
    task automatic run_one(input string r, input bit [2:0] ctx, input bit [31:0] a, input bit wr);
        int kind, ekind;
        bit [31:0] pa, epa;
        bit [2:0] code, ecode;
        bit ex;
        model(ctx, a, wr, ekind, epa, ecode, ex);
        send(ctx, 8'h5A, a, wr, kind, pa, code);
        chk({r, " kind"}, kind, ekind);
        if (ekind == 2 && kind == 2) begin
            chk({r, " code"}, {29'b0, code}, {29'b0, ecode});
            chk("R9 fault addr", flt_addr, a);
            answer(1'b0);
            chk("R10 terminate rsp", {30'b0, rsp_valid, rsp_err}, 32'd3);
        end else if (ekind != 2) begin
            chk({r, " paddr"}, pa, epa);
            if (ekind == 0) chk("R7 exec", {31'b0, rsp_exec}, {31'b0, ex});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int kind;
        bit [31:0] pa;
        bit [2:0] code;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R9 reset irq", {31'b0, flt_irq}, 0);
        chk("R1 reset rsp_valid", {31'b0, rsp_valid}, 0);
        chk("R11 reset ready", {31'b0, req_ready}, 1);

        // R1 R2: one entry of each size in context 1.
        prog(0, 1, 1, 0, 0, 32'h0001_2000, 32'h8000_5000, 3'b011);
        prog(1, 1, 1, 1, 0, 32'h0010_0000, 32'h4003_0000, 3'b111);
        prog(2, 1, 1, 2, 0, 32'h0300_0000, 32'h5560_0000, 3'b011);
        prog(3, 1, 1, 3, 0, 32'hFE00_0000, 32'h0100_0000, 3'b011);
        run_one("R1 4K", 1, 32'h0001_2ABC, 0);
        run_one("R2 64K", 1, 32'h0010_1234, 1);
        run_one("R2 1M", 1, 32'h030A_BCDE, 0);
        run_one("R2 16M", 1, 32'hFE12_3456, 1);
        // R5: window wins over the 16M entry; just outside translates.
        run_one("R5 bypass low", 1, 32'hFEE0_0010, 0);
        run_one("R5 bypass high", 1, 32'hFEEF_FFFC, 1);
        run_one("R5 outside", 1, 32'hFEF0_0000, 0);
        run_one("R5 below", 1, 32'hFEDF_FFF0, 0);
        // R3: misaligned write rejected, slot 4 stays empty -> R8 miss.
        prog(4, 1, 1, 0, 0, 32'h0000_1004, 32'h9000_0000, 3'b011);
        run_one("R8 miss", 1, 32'h0000_1004, 0);
        // R4: other context misses.
        run_one("R4 ctx", 2, 32'h0001_2ABC, 0);
        // R12: 4K inside the 64K page wins.
        prog(5, 1, 1, 0, 0, 32'h0010_3000, 32'h7777_7000, 3'b011);
        run_one("R12 small", 1, 32'h0010_3010, 0);
        run_one("R12 large", 1, 32'h0010_4010, 0);
        // R7 R9 R10: write to read-only page, then retry after remap.
        prog(6, 1, 3, 0, 0, 32'h2000_0000, 32'h3000_0000, 3'b001);
        send(3, 8'hC3, 32'h2000_0444, 1, kind, pa, code);
        chk("R7 write deny kind", kind, 2);
        chk("R7 write deny code", {29'b0, code}, 5);
        chk("R9 rid", {24'b0, flt_rid}, 32'hC3);
        chk("R9 addr", flt_addr, 32'h2000_0444);
        chk("R9 ready low", {31'b0, req_ready}, 0);
        prog(6, 1, 3, 0, 0, 32'h2000_0000, 32'h3000_0000, 3'b111);
        chk("R9 still held", {31'b0, flt_irq}, 1);
        answer(1'b1);
        chk("R10 retry valid", {31'b0, rsp_valid}, 1);
        chk("R10 retry paddr", rsp_paddr, 32'h3000_0444);
        chk("R7 exec bit", {31'b0, rsp_exec}, 1);
        prog(7, 1, 3, 0, 0, 32'h2100_0000, 32'h3100_0000, 3'b010);
        run_one("R7 read deny", 3, 32'h2100_0008, 0);
        // R6: split half tags.
        prog(7, 1, 4, 0, 1, 32'h8000_0000, 32'h1234_5000, 3'b011);
        set_split(4, 1);
        run_one("R6 split high", 4, 32'h8000_0040, 0);
        set_split(4, 0);
        run_one("R6 split off", 4, 32'h8000_0040, 0);
        // R11: stall between update strobes.
        @(negedge clk); upd_start = 1;
        @(negedge clk); upd_start = 0; req_valid = 1; req_ctx = 1; req_addr = 32'h0001_2000; req_wr = 0;
        @(negedge clk);
        chk("R11 stalled", {30'b0, req_ready, rsp_valid}, 0);
        @(negedge clk);
        chk("R11 stalled 2", {31'b0, req_ready}, 0);
        upd_done = 1;
        @(negedge clk); upd_done = 0;
        chk("R11 released", {31'b0, req_ready}, 1);
        @(negedge clk); req_valid = 0;
        chk("R11 served", rsp_paddr, 32'h8000_5000);
        // R13: invalidate context 1 only.
        @(negedge clk); inv_en = 1; inv_ctx = 1;
        @(negedge clk); inv_en = 0;
        for (int i = 0; i < 8; i++) if (m_ctx[i] == 1) m_valid[i] = 0;
        run_one("R13 gone", 1, 32'h0001_2ABC, 0);
        run_one("R13 gone 16M", 1, 32'hFE12_3456, 0);
        run_one("R13 kept", 3, 32'h2000_0010, 0);
        // R14: response held under back-pressure.
        @(negedge clk); rsp_ready = 0;
        send(3, 8'h11, 32'h2000_0020, 0, kind, pa, code);
        chk("R14 first", pa, 32'h3000_0020);
        repeat (3) @(negedge clk);
        chk("R14 held", {30'b0, rsp_valid, req_ready}, 32'd2);
        chk("R14 stable", rsp_paddr, 32'h3000_0020);
        rsp_ready = 1;
        @(negedge clk);
        chk("R14 drained", {31'b0, rsp_valid}, 0);

        // Random phase.
        for (int round = 0; round < 20; round++) begin
            for (int e = 0; e < 8; e++) begin
                bit [1:0] sz = 2'($urandom_range(0, 3));
                prog(3'(e), 1, 3'($urandom_range(0, 3)), sz, 1'($urandom_range(0, 1)),
                     $urandom & ~omask(sz), $urandom & ~omask(sz), 3'($urandom_range(0, 7)));
            end
            for (int c = 0; c < 4; c++) set_split(3'(c), 1'($urandom_range(0, 1)));
            for (int n = 0; n < 20; n++) begin
                int j = $urandom_range(0, 7);
                bit [31:0] a;
                bit [2:0] c;
                if ($urandom_range(0, 3) != 0) begin
                    a = m_vb[j] | ($urandom & omask(m_size[j]));
                    c = ($urandom_range(0, 4) != 0) ? m_ctx[j] : 3'($urandom_range(0, 3));
                end else begin
                    a = $urandom;
                    c = 3'($urandom_range(0, 3));
                end
                run_one("R1 random", c, a, 1'($urandom_range(0, 1)));
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule